// File: doc/BRIEF.md
# Token-Reversal Gray Code Sequencer

This block produces the reflected Gray code sequence without any binary count or XOR. It runs a token game on a small multigraph instead. Each output bit belongs to a main node of weight 1. The least significant main node has two mirror nodes, and every other main node has one mirror node. Each link between two nodes holds a fixed number of tokens, and each token points toward one of the two endpoints.

A node is *ready* when every link that touches it has at least that node's weight of tokens pointing at it. On every enabled clock, all ready nodes fire together. Each firing node turns its weight of tokens toward every neighbour. A main node's output bit is 1 while that node is ready. The link totals, the node weights and the starting token directions are chosen so that the ready pattern of the main nodes steps through the Gray sequence.

The width is fixed at elaboration to 2 or 3 bits. The `run` input gates the stepping. A synchronous reset restores the starting token directions.

Top module: `smer_gray_seq`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `gray` reads all zeros.
- R2: Each clock edge with `run` high and `rst` low moves `gray` to the next code of 000, 001, 011, 010, 110, 111, 101, 100 (bit 0 is the least significant main node).
- R3: After 2^WIDTH enabled steps, `gray` returns to all zeros, and the cycle repeats without end.
- R4: A clock edge with `run` low leaves `gray` and all token directions unchanged. The next enabled step continues from the held code.
- R5: Across any clock edge at most one bit of `gray` changes, and exactly one bit changes when `run` is high.
- R6: In every reachable state at least one node is ready, and no two linked nodes are ready together, so the sequence never stalls over many laps.
- R7: With WIDTH = 2 the enabled sequence is 00, 01, 11, 10, repeating.
- R8: Asserting `rst` in the middle of the sequence restarts it at all zeros, and the next enabled step gives code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restores the starting token directions |
| run | input | 1 | Enables one token-game step per clock |
| gray | output | WIDTH | Ready flags of the main nodes, bit 0 least significant |

## Verification
The hardest points are the two places where a main bit stays at 1 for two steps in a row. A wrong link total or a wrong starting direction there either lets a mirror fire one step early, which produces a two-bit jump or a repeated code, or blocks every node, which freezes the output for good. The bench walks several full laps on both widths and compares every step against the ideal sequence. This exposes a cycle that drifts on the second lap even when the first lap is correct. It also drops `run` for single cycles and for longer gaps, which would reveal a link that still moves tokens while stalled. Finally, it applies reset partway through a lap, which catches a counter that does not reload its starting orientation.

// File: rtl/smer_gray_pkg.sv
package smer_gray_pkg;

    localparam int CNT_W  = 3;
    localparam int IDX_W  = 4;

    typedef logic [CNT_W-1:0] tok_t;

    typedef struct packed {
        logic [IDX_W-1:0] end_a;
        logic [IDX_W-1:0] end_b;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] init_a;
    } link_desc_t;

    function automatic int node_count(input int w);
        return 2 * w + 1;
    endfunction

    function automatic int link_count(input int w);
        return (w == 2) ? 5 : 9;
    endfunction

    // Node order: mains 0..w-1, mirrors w..2w-1, second LSB mirror at 2w.
    function automatic int node_weight(input int w, input int n);
        if (n < w)       return 1;
        if (n == 2 * w)  return 2;
        if (n == w)      return 2;
        return (w == 2) ? 2 : 4;
    endfunction

    function automatic link_desc_t mk(input int a, input int b, input int t, input int ia);
        link_desc_t d;
        d.end_a  = IDX_W'(a);
        d.end_b  = IDX_W'(b);
        d.total  = CNT_W'(t);
        d.init_a = CNT_W'(ia);
        return d;
    endfunction

    // Links: endpoints, token total, tokens initially pointing at end_a.
    function automatic link_desc_t link_desc(input int w, input int k);
        link_desc_t d;
        d = mk(0, 0, 0, 0);
        if (w == 2) begin
            case (k)
                0: d = mk(0, 2, 2, 0);
                1: d = mk(0, 4, 2, 2);
                2: d = mk(2, 4, 3, 3);
                3: d = mk(1, 3, 2, 0);
                4: d = mk(2, 3, 3, 2);
                default: d = mk(0, 0, 0, 0);
            endcase
        end else begin
            case (k)
                0: d = mk(0, 3, 2, 0);
                1: d = mk(0, 6, 2, 2);
                2: d = mk(3, 6, 3, 3);
                3: d = mk(1, 4, 4, 0);
                4: d = mk(3, 4, 5, 2);
                5: d = mk(4, 5, 6, 4);
                6: d = mk(2, 5, 4, 0);
                7: d = mk(0, 5, 4, 2);
                8: d = mk(3, 5, 5, 2);
                default: d = mk(0, 0, 0, 0);
            endcase
        end
        return d;
    endfunction

    // Successor in reflected Gray order, for checking only.
    function automatic logic [7:0] gray_succ(input logic [7:0] g, input int w);
        logic [7:0] b;
        logic [7:0] mask;
        b[7] = g[7];
        for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        mask = 8'((1 << w) - 1);
        b = (b + 8'd1) & mask;
        return (b ^ (b >> 1)) & mask;
    endfunction

endpackage

// File: rtl/smer_link.sv
module smer_link
    import smer_gray_pkg::*;
#(
    parameter int TOTAL  = 2,
    parameter int INIT_A = 0,
    parameter int WT_A   = 1,
    parameter int WT_B   = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fire_a,
    input  logic fire_b,
    output tok_t tok_a,
    output tok_t tok_b
);
    localparam tok_t TOT_T  = tok_t'(TOTAL);
    localparam tok_t INIT_T = tok_t'(INIT_A);
    localparam tok_t WA_T   = tok_t'(WT_A);
    localparam tok_t WB_T   = tok_t'(WT_B);

    tok_t give_up;
    tok_t take_in;

    always_comb begin
        give_up = fire_a ? WA_T : '0;
        take_in = fire_b ? WB_T : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_a <= INIT_T;
        end else if (run) begin
            tok_a <= tok_a - give_up + take_in;
        end
    end

    assign tok_b = TOT_T - tok_a;

endmodule

// File: rtl/smer_node.sv
module smer_node
    import smer_gray_pkg::*;
#(
    parameter int WIDTH = 3,
    parameter int NODE  = 0,
    localparam int NL   = link_count(WIDTH),
    localparam int WT   = node_weight(WIDTH, NODE)
) (
    input  tok_t tok_a [NL],
    input  tok_t tok_b [NL],
    output logic ready
);
    localparam tok_t WT_T = tok_t'(WT);

    always_comb begin
        link_desc_t d;
        ready = 1'b1;
        for (int k = 0; k < NL; k++) begin
            d = link_desc(WIDTH, k);
            if (int'(d.end_a) == NODE && tok_a[k] < WT_T) ready = 1'b0;
            if (int'(d.end_b) == NODE && tok_b[k] < WT_T) ready = 1'b0;
        end
    end

endmodule

// File: rtl/smer_gray_seq.sv
module smer_gray_seq
    import smer_gray_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [WIDTH-1:0] gray
);
    localparam int NN = node_count(WIDTH);
    localparam int NL = link_count(WIDTH);

    if (!(WIDTH == 2 || WIDTH == 3)) begin : g_bad_width
        $error("smer_gray_seq supports WIDTH 2 or 3 only");
    end

    logic [NN-1:0] sink;
    tok_t          tok_a [NL];
    tok_t          tok_b [NL];

    for (genvar k = 0; k < NL; k++) begin : g_link
        localparam link_desc_t D = link_desc(WIDTH, k);
        localparam int EA = int'(D.end_a);
        localparam int EB = int'(D.end_b);

        smer_link #(
            .TOTAL  (int'(D.total)),
            .INIT_A (int'(D.init_a)),
            .WT_A   (node_weight(WIDTH, EA)),
            .WT_B   (node_weight(WIDTH, EB))
        ) u_link (
            .clk    (clk),
            .rst    (rst),
            .run    (run),
            .fire_a (sink[EA]),
            .fire_b (sink[EB]),
            .tok_a  (tok_a[k]),
            .tok_b  (tok_b[k])
        );
    end

    for (genvar n = 0; n < NN; n++) begin : g_node
        smer_node #(
            .WIDTH (WIDTH),
            .NODE  (n)
        ) u_node (
            .tok_a (tok_a),
            .tok_b (tok_b),
            .ready (sink[n])
        );
    end

    assign gray = sink[WIDTH-1:0];

endmodule

// File: rtl/smer_gray_chk.sv
module smer_gray_chk
    import smer_gray_pkg::*;
#(
    parameter int WIDTH = 3,
    localparam int NN   = node_count(WIDTH),
    localparam int NL   = link_count(WIDTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic [WIDTH-1:0] gray,
    input logic [NN-1:0]    sink
);

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> gray == '0);

    a_r2_next_code: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(run)) |->
            gray == WIDTH'(gray_succ(8'($past(gray)), WIDTH)));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(run)) |-> $stable(gray) && $stable(sink));

    a_r5_single_bit: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $countones(gray ^ $past(gray)) <= 1);

    a_r6_live: assert property (@(posedge clk) disable iff (rst)
        sink != '0);

    for (genvar k = 0; k < NL; k++) begin : g_excl
        localparam link_desc_t D = link_desc(WIDTH, k);
        a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
            !(sink[int'(D.end_a)] && sink[int'(D.end_b)]));
    end

endmodule

bind smer_gray_seq smer_gray_chk #(.WIDTH(WIDTH)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .gray (gray),
    .sink (sink)
);

// File: tb/smer_gray_seq_test.sv
module smer_gray_seq_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [2:0] g3;
    logic [1:0] g2;

    smer_gray_seq #(.WIDTH(3)) uut  (.clk(clk), .rst(rst), .run(run), .gray(g3));
    smer_gray_seq #(.WIDTH(2)) uut2 (.clk(clk), .rst(rst), .run(run), .gray(g2));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int step3 = 0;
    int step2 = 0;
    int enabled_steps = 0;
    bit armed = 1'b0;
    bit have_prev = 1'b0;
    bit last_rst = 1'b1;
    bit last_run = 1'b0;
    bit ever_ran = 1'b0;
    bit done = 1'b0;
    logic [2:0] prev3;
    logic [2:0] q3[$];
    logic [1:0] q2[$];

    initial begin
        for (int b = 0; b < 8; b++) q3.push_back(3'(b ^ (b >> 1)));
        for (int b = 0; b < 4; b++) q2.push_back(2'(b ^ (b >> 1)));
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Reference model: position in the ideal sequence.
    always @(posedge clk) begin
        last_rst <= rst;
        last_run <= run;
        if (rst) begin
            step3 <= 0;
            step2 <= 0;
            armed <= 1'b1;
        end else if (run) begin
            step3 <= (step3 + 1) % 8;
            step2 <= (step2 + 1) % 4;
            enabled_steps <= enabled_steps + 1;
            ever_ran <= 1'b1;
        end
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            string tag;
            if (last_rst)           tag = ever_ran ? "R8" : "R1";
            else if (!last_run)     tag = "R4";
            else if (step3 == 0)    tag = "R3";
            else if (enabled_steps > 8) tag = "R6";
            else                    tag = "R2";
            chk(tag, int'(g3), int'(q3[step3]));
            chk("R7", int'(g2), int'(q2[step2]));
            if (have_prev && !last_rst)
                chk("R5", $countones(g3 ^ prev3), last_run ? 1 : 0);
            prev3 = g3;
            have_prev = 1'b1;
        end
    end

    task automatic finish_up();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run = 1'b1;
        repeat (21) @(negedge clk);
        run = 1'b0;
        repeat (3) @(negedge clk);
        run = 1'b1;
        repeat (5) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            run = ~run;
            @(negedge clk);
        end
        run = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        run = 1'b0;
        repeat (2) @(negedge clk);
        finish_up();
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

endmodule